// File: doc/BRIEF.md
# Dual Digital Potentiometer Wiper Controller

This block holds the wiper settings of two digital potentiometers: pot A with 100 taps and pot B with 256 taps. It sits behind a two-wire bus slave front end that has already assembled whole bytes. For every byte, the front end gives the byte value, a flag saying whether it is an instruction byte or a data byte, the read/write direction of the current transfer and a one-cycle valid strobe. One cycle later the block answers with an acknowledge or a refusal.

An instruction byte chooses a pot and a write type. The data bytes that follow set that pot's volatile wiper. When the write type asks for it, they also set the pot's nonvolatile shadow copy. Pot B takes the data byte directly as its tap number. Pot A uses a folded code in four bands of 25 taps, where two of the bands count downwards. During a read, the front end takes the selected wiper value from `rd_data`.

After reset, the wipers hold fixed preset positions. Once the supply-good input has been stable for a set number of cycles, both wipers are loaded from their shadow copies. If the supply drops and comes back, the same load happens again. The shadow copies are kept across a supply drop and lose their contents only on reset.

Top module: `dpot_wiper_ctrl`

## Requirements
- R1: An instruction byte whose bits 6..2 are all zero and whose bits 1..0 are 01 (pot A) or 10 (pot B) is acknowledged. The response appears on `ack_vld`/`ack` in the cycle after the byte strobe, and every strobed byte gets exactly one such response.
- R2: An instruction byte with bits 1..0 equal to 00 or 11, or with any of bits 6..2 set, is refused. Data bytes that follow it are also refused and leave both taps unchanged.
- R3: Bit 7 of the instruction byte is the write type. With 1, a data byte updates both the wiper and its shadow. With 0, it updates only the wiper, so the next recall brings back the last shadow value.
- R4: For pot B, the accepted data byte becomes the tap number directly (0..255).
- R5: For pot A, a data code c gives these taps: c for c in 0..24, 81-c for c in 32..56, c-14 for c in 64..88, and 195-c for c in 96..120.
- R6: Any pot A code outside those four ranges, including every code above 120, sets tap 99. `tap_a` never goes above 99 and never wraps around to 0.
- R7: After reset, `tap_a` is 0, `tap_b` is 255, `recall_done` is 0, no response is pending, and both shadows hold 00h.
- R8: Both wipers are loaded from their shadows once the synchronised `supply_ok` has been high for RECALL_CYCLES cycles, and `recall_done` then rises. A low supply clears `recall_done` and restarts the count. The shadows keep their values across the drop.
- R9: A data write is refused and changes no tap when `wel` is 0, when `block_lock` is nonzero, or when recall has not completed.
- R10: An accepted data byte takes effect on `tap_a`/`tap_b` at the clock edge that samples its strobe. The old value is still shown while the strobe is high.
- R11: A read instruction (`rd_flag`=1) ignores bit 7. Pot A then reads as the code of its current tap with bit 7 at 0, and pot B reads as its tap. A data byte marked as a read is refused and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-good level, asynchronous |
| byte_vld | input | 1 | One-cycle strobe marking a received byte |
| byte_is_instr | input | 1 | 1: instruction byte, 0: data byte |
| rd_flag | input | 1 | Direction of the current transfer, 1 = read |
| byte_in | input | 8 | Received byte value |
| wel | input | 1 | Write enable latch state |
| block_lock | input | 2 | Block-lock setting; any nonzero value forbids writes |
| ack_vld | output | 1 | Response valid, one cycle after each strobe |
| ack | output | 1 | 1 = acknowledge, 0 = refuse |
| rd_data | output | 8 | Wiper value of the selected pot for reads |
| tap_a | output | 7 | Pot A tap position, 0..99 |
| tap_b | output | 8 | Pot B tap position, 0..255 |
| recall_done | output | 1 | Wipers have been loaded from the shadows |

## Verification
The assertions assume that `byte_vld` is a single-cycle strobe and that `byte_is_instr`, `rd_flag`, `byte_in`, `wel` and `block_lock` are steady whenever it is sampled. They also assume that the permission inputs do not change around a recall. The bench keeps within these assumptions: it drives every input on the falling edge, holds each strobe for exactly one cycle and drops it again, and changes `wel`/`block_lock` only while no byte is in flight. It also lets `supply_ok` settle for many cycles before each check on the recall.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

  localparam int BYTE_W  = 8;
  localparam int A_TAP_W = 7;
  localparam int B_TAP_W = 8;
  localparam int A_TAPS  = 100;
  localparam int A_TOP   = A_TAPS - 1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_A    = 2'b01,
    SEL_B    = 2'b10,
    SEL_RSV  = 2'b11
  } pot_sel_e;

  // Folded code of pot A -> tap; unmapped codes pin to the top tap
  function automatic logic [A_TAP_W-1:0] a_code_to_tap(input logic [BYTE_W-1:0] code);
    int c;
    int t;
    c = int'(code);
    if (c <= 24)                 t = c;
    else if (c >= 32 && c <= 56) t = 81 - c;
    else if (c >= 64 && c <= 88) t = c - 14;
    else if (c >= 96 && c <= 120) t = 195 - c;
    else                         t = A_TOP;
    return A_TAP_W'(t);
  endfunction

  // Tap of pot A -> folded code (inverse of the above)
  function automatic logic [A_TAP_W-1:0] a_tap_to_code(input logic [A_TAP_W-1:0] tap);
    int t;
    int c;
    t = int'(tap);
    if (t < 25)      c = t;
    else if (t < 50) c = 81 - t;
    else if (t < 75) c = t + 14;
    else             c = 195 - t;
    return A_TAP_W'(c);
  endfunction

endpackage

// File: rtl/dpot_cmd_decode.sv
module dpot_cmd_decode
  import dpot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_stb,
  input  logic [BYTE_W-1:0] instr_byte,
  output logic              instr_ok,
  output pot_sel_e          sel,
  output logic              wr_nv
);

  pot_sel_e sel_q, sel_n;
  logic     nv_q, nv_n;
  logic     pad_zero;
  logic     sel_legal;

  assign pad_zero  = (instr_byte[6:2] == 5'b00000);
  assign sel_legal = (instr_byte[1:0] == SEL_A) || (instr_byte[1:0] == SEL_B);
  assign instr_ok  = pad_zero && sel_legal;

  always_comb begin
    sel_n = sel_q;
    nv_n  = nv_q;
    if (instr_stb) begin
      if (instr_ok) begin
        sel_n = pot_sel_e'(instr_byte[1:0]);
        nv_n  = instr_byte[7];
      end else begin
        sel_n = SEL_NONE;
        nv_n  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_NONE;
      nv_q  <= 1'b0;
    end else if (instr_stb) begin
      sel_q <= sel_n;
      nv_q  <= nv_n;
    end
  end

  assign sel   = sel_q;
  assign wr_nv = nv_q;

endmodule

// File: rtl/dpot_recall_seq.sv
module dpot_recall_seq #(
  parameter int RECALL_CYCLES = 1024,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic recall_load,
  output logic recall_done
);

  localparam int CNT_W = (RECALL_CYCLES > 2) ? $clog2(RECALL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RECALL_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   supply_s;
  logic [CNT_W-1:0]       cnt_q, cnt_n;
  logic                   done_q, done_n;
  logic                   load_n;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= supply_ok;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  assign supply_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    cnt_n  = cnt_q;
    done_n = done_q;
    load_n = 1'b0;
    if (!supply_s) begin
      cnt_n  = '0;
      done_n = 1'b0;
    end else if (!done_q) begin
      if (cnt_q == CNT_LAST) begin
        load_n = 1'b1;
        done_n = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      done_q <= done_n;
    end
  end

  assign recall_load = load_n;
  assign recall_done = done_q;

endmodule

// File: rtl/dpot_a_map.sv
module dpot_a_map
  import dpot_pkg::*;
(
  input  logic [BYTE_W-1:0]  wr_code,
  output logic [A_TAP_W-1:0] wr_tap,
  input  logic [A_TAP_W-1:0] cur_tap,
  output logic [BYTE_W-1:0]  rd_code
);

  logic [A_TAP_W-1:0] code7;

  always_comb begin
    wr_tap = a_code_to_tap(wr_code);
    code7  = a_tap_to_code(cur_tap);
    rd_code = {1'b0, code7};
  end

endmodule

// File: rtl/dpot_wiper_ctrl.sv
module dpot_wiper_ctrl
  import dpot_pkg::*;
#(
  parameter int RECALL_CYCLES = 1024,
  parameter int SYNC_STAGES   = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         supply_ok,
  input  logic         byte_vld,
  input  logic         byte_is_instr,
  input  logic         rd_flag,
  input  logic [7:0]   byte_in,
  input  logic         wel,
  input  logic [1:0]   block_lock,
  output logic         ack_vld,
  output logic         ack,
  output logic [7:0]   rd_data,
  output logic [6:0]   tap_a,
  output logic [7:0]   tap_b,
  output logic         recall_done
);

  localparam logic [A_TAP_W-1:0] A_PRESET = '0;
  localparam logic [B_TAP_W-1:0] B_PRESET = '1;

  logic instr_stb, data_stb;
  logic instr_ok;
  pot_sel_e sel;
  logic wr_nv;
  logic recall_load;
  logic wr_allowed, data_ok;
  logic [A_TAP_W-1:0] a_wr_tap;
  logic [BYTE_W-1:0]  a_rd_code;

  logic ack_vld_q, ack_q, ack_n;
  logic [A_TAP_W-1:0] wip_a_q, wip_a_n, shd_a_q, shd_a_n;
  logic [B_TAP_W-1:0] wip_b_q, wip_b_n, shd_b_q, shd_b_n;
  logic wip_en, shd_en;

  assign instr_stb = byte_vld &&  byte_is_instr;
  assign data_stb  = byte_vld && !byte_is_instr;

  dpot_cmd_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_stb  (instr_stb),
    .instr_byte (byte_in),
    .instr_ok   (instr_ok),
    .sel        (sel),
    .wr_nv      (wr_nv)
  );

  dpot_recall_seq #(
    .RECALL_CYCLES (RECALL_CYCLES),
    .SYNC_STAGES   (SYNC_STAGES)
  ) u_recall (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok   (supply_ok),
    .recall_load (recall_load),
    .recall_done (recall_done)
  );

  dpot_a_map u_amap (
    .wr_code (byte_in),
    .wr_tap  (a_wr_tap),
    .cur_tap (wip_a_q),
    .rd_code (a_rd_code)
  );

  assign wr_allowed = wel && (block_lock == 2'b00) && recall_done && !rd_flag;
  assign data_ok    = data_stb && wr_allowed && ((sel == SEL_A) || (sel == SEL_B));

  // Response
  always_comb begin
    ack_n = 1'b0;
    if (instr_stb)     ack_n = instr_ok;
    else if (data_stb) ack_n = data_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_vld_q <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      ack_vld_q <= byte_vld;
      ack_q     <= ack_n;
    end
  end

  // Wipers and shadows
  always_comb begin
    wip_a_n = wip_a_q;
    wip_b_n = wip_b_q;
    shd_a_n = shd_a_q;
    shd_b_n = shd_b_q;
    wip_en  = 1'b0;
    shd_en  = 1'b0;
    if (recall_load) begin
      wip_a_n = shd_a_q;
      wip_b_n = shd_b_q;
      wip_en  = 1'b1;
    end else if (data_ok) begin
      wip_en = 1'b1;
      shd_en = wr_nv;
      if (sel == SEL_A) begin
        wip_a_n = a_wr_tap;
        shd_a_n = a_wr_tap;
      end else begin
        wip_b_n = byte_in;
        shd_b_n = byte_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip_a_q <= A_PRESET;
      wip_b_q <= B_PRESET;
    end else if (wip_en) begin
      wip_a_q <= wip_a_n;
      wip_b_q <= wip_b_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_a_q <= '0;
      shd_b_q <= '0;
    end else if (shd_en) begin
      shd_a_q <= shd_a_n;
      shd_b_q <= shd_b_n;
    end
  end

  // Read path
  always_comb begin
    case (sel)
      SEL_A:   rd_data = a_rd_code;
      SEL_B:   rd_data = wip_b_q;
      default: rd_data = '0;
    endcase
  end

  assign ack_vld = ack_vld_q;
  assign ack     = ack_q;
  assign tap_a   = wip_a_q;
  assign tap_b   = wip_b_q;

endmodule

// File: rtl/dpot_wiper_chk.sv
module dpot_wiper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_vld,
  input logic       byte_is_instr,
  input logic [7:0] byte_in,
  input logic       wel,
  input logic [1:0] block_lock,
  input logic       ack_vld,
  input logic       ack,
  input logic [6:0] tap_a,
  input logic [7:0] tap_b,
  input logic       recall_done
);

  // R1
  response_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> ack_vld);

  // R1
  no_unsolicited_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> !ack_vld);

  // R2
  reserved_select_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_is_instr && (byte_in[1:0] == 2'b00 || byte_in[1:0] == 2'b11))
    |=> (ack_vld && !ack));

  // R9
  locked_write_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !byte_is_instr && recall_done && (!wel || block_lock != 2'b00))
    |=> ($stable(tap_a) && $stable(tap_b) && !ack));

  // R6
  tap_a_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_a <= 7'd99);

endmodule

bind dpot_wiper_ctrl dpot_wiper_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .byte_vld      (byte_vld),
  .byte_is_instr (byte_is_instr),
  .byte_in       (byte_in),
  .wel           (wel),
  .block_lock    (block_lock),
  .ack_vld       (ack_vld),
  .ack           (ack),
  .tap_a         (tap_a),
  .tap_b         (tap_b),
  .recall_done   (recall_done)
);

// File: tb/dpot_wiper_ctrl_tb.sv
module dpot_wiper_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int RECALL     = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_ok = 1'b0;
  logic       byte_vld = 1'b0;
  logic       byte_is_instr = 1'b0;
  logic       rd_flag = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic       wel = 1'b0;
  logic [1:0] block_lock = 2'b00;
  logic       ack_vld, ack, recall_done;
  logic [7:0] rd_data, tap_b;
  logic [6:0] tap_a;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpot_wiper_ctrl #(.RECALL_CYCLES(RECALL), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .byte_vld(byte_vld),
    .byte_is_instr(byte_is_instr), .rd_flag(rd_flag), .byte_in(byte_in),
    .wel(wel), .block_lock(block_lock), .ack_vld(ack_vld), .ack(ack),
    .rd_data(rd_data), .tap_a(tap_a), .tap_b(tap_b), .recall_done(recall_done)
  );

  function automatic int ref_tap(int c);
    if (c >= 0 && c < 25)   return c;
    if (c > 31 && c < 57)   return 81 - c;
    if (c > 63 && c < 89)   return c - 14;
    if (c > 95 && c < 121)  return 195 - c;
    return 99;
  endfunction

  function automatic int ref_code(int t);
    if (t >= 75) return 195 - t;
    if (t >= 50) return t + 14;
    if (t >= 25) return 81 - t;
    return t;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Send one byte; returns the response sampled after the strobe edge
  task automatic send(input bit instr, input bit rd, input logic [7:0] b, output bit got_ack);
    @(negedge clk);
    byte_vld = 1'b1; byte_is_instr = instr; rd_flag = rd; byte_in = b;
    @(negedge clk);
    byte_vld = 1'b0;
    chk("R1", "ack_vld after byte", int'(ack_vld), 1);
    got_ack = ack;
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R7", "tap_a reset", int'(tap_a), 0);
    chk("R7", "tap_b reset", int'(tap_b), 255);
    chk("R7", "recall_done reset", int'(recall_done), 0);
    chk("R7", "ack_vld reset", int'(ack_vld), 0);
  endtask

  task automatic t_before_recall;
    bit a;
    wel = 1'b1;
    send(1, 0, 8'h02, a); chk("R1", "instr B ack", int'(a), 1);
    send(0, 0, 8'h44, a); chk("R9", "write before recall nack", int'(a), 0);
    chk("R9", "tap_b held before recall", int'(tap_b), 255);
  endtask

  task automatic t_recall_first;
    supply_ok = 1'b1;
    wait_cycles(6);
    chk("R8", "recall_done early", int'(recall_done), 0);
    chk("R7", "tap_b preset kept", int'(tap_b), 255);
    wait_cycles(RECALL + 6);
    chk("R8", "recall_done set", int'(recall_done), 1);
    chk("R7", "tap_a from factory shadow", int'(tap_a), 0);
    chk("R7", "tap_b from factory shadow", int'(tap_b), 0);
  endtask

  task automatic t_write_b;
    bit a;
    send(1, 0, 8'h02, a); chk("R1", "instr B ack", int'(a), 1);
    @(negedge clk);
    byte_vld = 1'b1; byte_is_instr = 1'b0; rd_flag = 1'b0; byte_in = 8'h5A;
    #1;
    chk("R10", "tap_b before edge", int'(tap_b), 0);
    @(negedge clk);
    byte_vld = 1'b0;
    chk("R1", "data ack_vld", int'(ack_vld), 1);
    chk("R9", "data ack", int'(ack), 1);
    chk("R10", "tap_b after edge", int'(tap_b), 8'h5A);
    send(0, 0, 8'hFF, a);
    chk("R4", "tap_b top code", int'(tap_b), 255);
    send(0, 0, 8'h00, a);
    chk("R4", "tap_b zero code", int'(tap_b), 0);
  endtask

  task automatic t_map_a;
    bit a;
    send(1, 0, 8'h01, a); chk("R1", "instr A ack", int'(a), 1);
    for (int c = 0; c < 256; c++) begin
      send(0, 0, 8'(c), a);
      if (ref_tap(c) == 99 && !((c > 95 && c < 121)))
        chk("R6", $sformatf("code %0d", c), int'(tap_a), ref_tap(c));
      else
        chk("R5", $sformatf("code %0d", c), int'(tap_a), ref_tap(c));
    end
  endtask

  task automatic t_read;
    bit a;
    send(1, 0, 8'h01, a);
    send(0, 0, 8'd40, a);
    chk("R5", "tap_a code 40", int'(tap_a), 41);
    send(1, 1, 8'h81, a); chk("R11", "read instr WT ignored", int'(a), 1);
    chk("R11", "rd_data pot A", int'(rd_data), ref_code(41));
    send(0, 1, 8'd5, a); chk("R11", "read-data nack", int'(a), 0);
    chk("R11", "tap_a unchanged by read data", int'(tap_a), 41);
    send(1, 0, 8'h01, a);
    send(0, 0, 8'd110, a);
    send(1, 1, 8'h01, a);
    chk("R11", "rd_data A bit7 zero", int'(rd_data), 110);
    send(1, 0, 8'h02, a);
    send(0, 0, 8'hC3, a);
    send(1, 1, 8'h02, a);
    chk("R11", "rd_data pot B", int'(rd_data), 8'hC3);
  endtask

  task automatic t_reserved;
    bit a;
    logic [6:0] ta;
    logic [7:0] tb;
    ta = tap_a; tb = tap_b;
    send(1, 0, 8'h00, a); chk("R2", "select 00 nack", int'(a), 0);
    send(0, 0, 8'h10, a); chk("R2", "data after 00 nack", int'(a), 0);
    send(1, 0, 8'h83, a); chk("R2", "select 11 nack", int'(a), 0);
    send(1, 0, 8'h05, a); chk("R2", "pad bit set nack", int'(a), 0);
    send(0, 0, 8'h10, a); chk("R2", "data after bad pad nack", int'(a), 0);
    chk("R2", "tap_a unchanged", int'(tap_a), int'(ta));
    chk("R2", "tap_b unchanged", int'(tap_b), int'(tb));
  endtask

  task automatic t_protect;
    bit a;
    send(1, 0, 8'h02, a);
    wel = 1'b0;
    send(0, 0, 8'h11, a); chk("R9", "wel clear nack", int'(a), 0);
    chk("R9", "tap_b kept wel", int'(tap_b), 8'hC3);
    wel = 1'b1; block_lock = 2'b01;
    send(0, 0, 8'h22, a); chk("R9", "lock 01 nack", int'(a), 0);
    block_lock = 2'b10;
    send(0, 0, 8'h22, a); chk("R9", "lock 10 nack", int'(a), 0);
    chk("R9", "tap_b kept lock", int'(tap_b), 8'hC3);
    block_lock = 2'b00;
    send(0, 0, 8'h22, a); chk("R9", "unlocked ack", int'(a), 1);
    chk("R9", "tap_b written", int'(tap_b), 8'h22);
  endtask

  task automatic t_nonvol;
    bit a;
    send(1, 0, 8'h81, a); chk("R3", "nv instr A ack", int'(a), 1);
    send(0, 0, 8'd10, a);
    send(1, 0, 8'h01, a);
    send(0, 0, 8'd64, a);
    chk("R3", "volatile A tap", int'(tap_a), 50);
    send(1, 0, 8'h82, a);
    send(0, 0, 8'h33, a);
    send(1, 0, 8'h02, a);
    send(0, 0, 8'h77, a);
    chk("R3", "volatile B tap", int'(tap_b), 8'h77);
    supply_ok = 1'b0;
    wait_cycles(5);
    chk("R8", "done cleared on drop", int'(recall_done), 0);
    supply_ok = 1'b1;
    wait_cycles(4);
    supply_ok = 1'b0;
    wait_cycles(4);
    supply_ok = 1'b1;
    wait_cycles(8);
    chk("R8", "count restarted", int'(recall_done), 0);
    chk("R8", "tap_a held until recall", int'(tap_a), 50);
    wait_cycles(RECALL + 6);
    chk("R8", "done after restart", int'(recall_done), 1);
    chk("R3", "tap_a recalled nv", int'(tap_a), 10);
    chk("R3", "tap_b recalled nv", int'(tap_b), 8'h33);
  endtask

  initial begin
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(2);
    t_reset();
    t_before_recall();
    t_recall_first();
    t_write_b();
    t_map_a();
    t_read();
    t_reserved();
    t_protect();
    t_nonvol();
    wait_cycles(2);
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule